// File: doc/BRIEF.md
# PCM Sample Pacer and Block Counter

This block paces a PCM audio stream with two down-counting rate generators that reload themselves. The first divides a source tick into a one-cycle sample strobe. The second counts those strobes and sets a sticky interrupt when a block of transfers is complete. Software programs both channels through a byte-wide write port. For each channel it writes a control word, then the count as a low byte followed by a high byte. It then opens the gates that let the channels run.

A DMA-width input selects how the block counter relates to strobes. On 8-bit channels each strobe is one transfer. On 16-bit channels software programs half the byte count, so the counter advances on every second strobe. A master PCM enable freezes both channels. While it is low, software can load a new block length, and counting resumes from that length when the enable is set again.

Top module: `pcm_pacer`

## Requirements
- R1: The register map is 0 = rate count, 1 = block count, 2 = control (data bit 0 selects channel 0 or 1), 3 = gates (bit 0 rate enable, bit 1 block enable, bit 2 PCM enable, all active-high), 4 = acknowledge (bit 0).
- R2: A count byte written to a channel that has had no control write since reset is ignored, and that channel does not run.
- R3: With all gates set, the rate channel emits a one-cycle strobe once every N source ticks. N is the low byte of the loaded count, and 0 stands for 256. The high byte is accepted on the bus and discarded.
- R4: With an 8-bit DMA width, the block counter advances once per strobe and sets the interrupt in the same cycle as its Nth strobe. A loaded count of 0 stands for 65536.
- R5: A block count of 1 never raises the interrupt.
- R6: With the 16-bit DMA flag set, the block counter advances on every second strobe, so the interrupt arrives with strobe 2N.
- R7: While its enable bit is 0, a channel holds its count: no strobes come from a closed rate channel, and no interrupt from a closed block channel.
- R8: While PCM enable is 0, no strobe appears. A block count loaded in that time is the one counted once the enable returns.
- R9: The interrupt stays high until a write to the acknowledge address with bit 0 set. A write with bit 0 clear has no effect.
- R10: Synchronous reset clears the interrupt, the gates, the loaded counts and the strobe output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW (8) | Write data |
| dma16 | input | 1 | 1 when the DMA channel is 16 bits wide |
| src_tick | input | 1 | Source clock enable for the rate channel |
| samp_strobe | output | 1 | One-cycle sample strobe, registered |
| irq | output | 1 | Sticky end-of-block interrupt |

## Verification
A wrong count in either channel shows up at the ports within one programmed period. A corrupted rate counter moves the strobe spacing away from N cycles on the very next strobe. A block counter that is off by even one moves the interrupt to a different strobe index, and the bench records that index exactly. Faults in the gates, the byte pointer or the half-rate divider show up as strobes or interrupts that appear when none are due, or that are missing when they are due.

// File: rtl/pcm_pacer_pkg.sv
package pcm_pacer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_RATE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_BUF  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_GATE = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACK  = 3'd4;

  typedef struct packed {
    logic pcm;
    logic buf_en;
    logic rate_en;
  } gate_t;
endpackage

// File: rtl/pcm_pacer_regs.sv
module pcm_pacer_regs
  import pcm_pacer_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RATE_W = 8,
  parameter int BUF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output gate_t             gate,
  output logic [1:0]        valid,
  output logic [1:0]        load_go,
  output logic [RATE_W-1:0] rate_reload,
  output logic [BUF_W-1:0]  buf_reload,
  output logic              ack
);
  localparam int HI_W = BUF_W - DW;

  logic [1:0]    armed;
  logic [1:0]    ptr;
  logic [DW-1:0] lo_stage [2];
  logic          sel;
  logic          csel;
  logic          is_cnt;

  assign sel    = wr_addr[0];
  assign csel   = wr_data[0];
  assign is_cnt = wr_en && (wr_addr == ADR_RATE || wr_addr == ADR_BUF);
  assign ack    = wr_en && (wr_addr == ADR_ACK) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      gate        <= '0;
      armed       <= '0;
      ptr         <= '0;
      valid       <= '0;
      load_go     <= '0;
      rate_reload <= '0;
      buf_reload  <= '0;
      lo_stage[0] <= '0;
      lo_stage[1] <= '0;
    end else begin
      load_go <= '0;
      if (wr_en && wr_addr == ADR_CTRL) begin
        armed[csel] <= 1'b1;
        ptr[csel]   <= 1'b0;
        valid[csel] <= 1'b0;
      end
      if (is_cnt && armed[sel]) begin
        if (!ptr[sel]) begin
          lo_stage[sel] <= wr_data;
          ptr[sel]      <= 1'b1;
        end else begin
          ptr[sel]     <= 1'b0;
          valid[sel]   <= 1'b1;
          load_go[sel] <= 1'b1;
          if (sel) buf_reload  <= {wr_data[HI_W-1:0], lo_stage[1]};
          else     rate_reload <= lo_stage[0][RATE_W-1:0];
        end
      end
      if (wr_en && wr_addr == ADR_GATE) gate <= gate_t'(wr_data[2:0]);
    end
  end
endmodule

// File: rtl/pcm_pacer_chan.sv
module pcm_pacer_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_go,
  input  logic [W-1:0] reload,
  input  logic         tick,
  output logic         tc
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  // A period of 1 is not a legal divisor: it reloads forever and never signals.
  assign tc = tick && !load_go && (cnt == ONE) && (reload != ONE);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load_go) cnt <= reload;
    else if (tick) begin
      if (cnt == ONE) cnt <= reload;
      else            cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/pcm_pacer.sv
module pcm_pacer
  import pcm_pacer_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RATE_W = 8,
  parameter int BUF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              dma16,
  input  logic              src_tick,
  output logic              samp_strobe,
  output logic              irq
);
  gate_t             gate;
  logic [1:0]        valid;
  logic [1:0]        load_go;
  logic [RATE_W-1:0] rate_reload;
  logic [BUF_W-1:0]  buf_reload;
  logic              ack;
  logic              rate_tick, rate_tc;
  logic              buf_adv, buf_tick, buf_tc;
  logic              half_q;
  logic              pcm_on;

  pcm_pacer_regs #(.DW(DW), .RATE_W(RATE_W), .BUF_W(BUF_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate(gate), .valid(valid), .load_go(load_go),
    .rate_reload(rate_reload), .buf_reload(buf_reload), .ack(ack)
  );

  assign pcm_on    = gate.pcm;
  assign rate_tick = src_tick && gate.rate_en && pcm_on && valid[0];

  pcm_pacer_chan #(.W(RATE_W)) rate_i (
    .clk(clk), .rst(rst), .load_go(load_go[0]), .reload(rate_reload),
    .tick(rate_tick), .tc(rate_tc)
  );

  assign buf_adv  = rate_tc && gate.buf_en && pcm_on && valid[1];
  assign buf_tick = buf_adv && (!dma16 || half_q);

  always_ff @(posedge clk) begin
    if (rst || !pcm_on || load_go[1]) half_q <= 1'b0;
    else if (buf_adv)                 half_q <= ~half_q;
  end

  pcm_pacer_chan #(.W(BUF_W)) buf_i (
    .clk(clk), .rst(rst), .load_go(load_go[1]), .reload(buf_reload),
    .tick(buf_tick), .tc(buf_tc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_strobe <= 1'b0;
      irq         <= 1'b0;
    end else begin
      samp_strobe <= rate_tc;
      if (buf_tc)   irq <= 1'b1;
      else if (ack) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_pacer_chk.sv
module pcm_pacer_chk #(
  parameter int DW    = 8,
  parameter int BUF_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             samp_strobe,
  input logic             irq,
  input logic             pcm_on,
  input logic [BUF_W-1:0] buf_reload
);
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    samp_strobe |=> !samp_strobe);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> irq);

  a_r4_irq_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> samp_strobe);

  a_r8_pcm_stops_strobe: assert property (@(posedge clk) disable iff (rst)
    !pcm_on |=> !samp_strobe);

  a_r5_count_one_silent: assert property (@(posedge clk) disable iff (rst)
    (buf_reload == BUF_W'(1) && !irq) |=> !irq);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!irq && !samp_strobe));
endmodule

bind pcm_pacer pcm_pacer_chk #(.DW(DW), .BUF_W(BUF_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .samp_strobe(samp_strobe), .irq(irq), .pcm_on(pcm_on), .buf_reload(buf_reload)
);

// File: tb/pcm_pacer_tb_top.sv
`timescale 1ns/1ps
module pcm_pacer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       dma16 = 1'b0;
  logic       src_tick = 1'b1;
  logic       samp_strobe, irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pcm_pacer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dma16(dma16), .src_tick(src_tick), .samp_strobe(samp_strobe), .irq(irq)
  );

  // Stimulus table: rate count, block count, 16-bit DMA, expected period, expected strobe index
  localparam int VN = 4;
  localparam logic [15:0] V_RATE [VN] = '{16'h1205, 16'h0002, 16'h0000, 16'h0007};
  localparam logic [15:0] V_BUF  [VN] = '{16'd3, 16'd4, 16'd2, 16'd5};
  localparam logic        V_DMA  [VN] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int          V_PER  [VN] = '{5, 2, 256, 7};
  localparam int          V_K    [VN] = '{3, 8, 2, 10};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input logic ch, input logic [15:0] v);
    wr(3'd2, {7'd0, ch});
    wr({2'b00, ch}, v[7:0]);
    wr({2'b00, ch}, v[15:8]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; dma16 = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic count_window(input int n, output int strobes, output int irqs);
    strobes = 0; irqs = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (samp_strobe) strobes++;
      if (irq) irqs++;
    end
  endtask

  task automatic run_block(input int per, input int k, input int limit, input string tag);
    int strobes = 0, k_at = -1, bad = 0, last = -1, got = -1;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (samp_strobe) begin
        strobes++;
        if (last >= 0) begin
          got = c - last;
          if (got != per) bad++;
        end
        last = c;
      end
      if (irq) begin
        k_at = strobes;
        break;
      end
    end
    check(k_at == k, {tag, " irq strobe index"}, k_at, k);
    check(bad == 0 && (k < 2 || got == per), {tag, " strobe period"}, got, per);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int s, q;
    // R10: reset state
    do_reset();
    @(negedge clk);
    check(samp_strobe == 0 && irq == 0, "R10 reset outputs", {samp_strobe, irq}, 0);

    // R1 R3 R4 R6: table of programmed blocks
    for (int i = 0; i < VN; i++) begin
      do_reset();
      prog(1'b0, V_RATE[i]);
      prog(1'b1, V_BUF[i]);
      dma16 = V_DMA[i];
      wr(3'd3, 8'h07);
      run_block(V_PER[i], V_K[i], 4000, V_DMA[i] ? "R6" : "R3 R4");
    end

    // R9: sticky interrupt, acknowledge bit 0 only
    wr(3'd3, 8'h03);
    count_window(10, s, q);
    check(irq == 1, "R9 irq holds", irq, 1);
    wr(3'd4, 8'h00);
    check(irq == 1, "R9 ack bit0 clear ignored", irq, 1);
    wr(3'd4, 8'h01);
    check(irq == 0, "R9 ack clears", irq, 0);

    // R7: rate gate closed holds, block gate closed blocks irq
    do_reset();
    prog(1'b0, 16'd5);
    prog(1'b1, 16'd20);
    wr(3'd3, 8'h07);
    count_window(12, s, q);
    wr(3'd3, 8'h06);
    count_window(30, s, q);
    check(s == 0, "R7 rate gate closed", s, 0);
    wr(3'd3, 8'h07);
    count_window(10, s, q);
    check(s >= 1, "R7 rate resumes", s, 1);
    wr(3'd3, 8'h05);
    count_window(200, s, q);
    check(q == 0 && s >= 30, "R7 block gate closed", q, 0);

    // R8: PCM enable off stops strobes; new block length used after restart
    do_reset();
    prog(1'b0, 16'd4);
    prog(1'b1, 16'd50);
    wr(3'd3, 8'h07);
    count_window(20, s, q);
    wr(3'd3, 8'h03);
    count_window(30, s, q);
    check(s == 0, "R8 pcm off no strobe", s, 0);
    prog(1'b1, 16'd3);
    wr(3'd3, 8'h07);
    run_block(4, 3, 200, "R8 restart");

    // R5: block count of one never interrupts
    do_reset();
    prog(1'b0, 16'd2);
    prog(1'b1, 16'd1);
    wr(3'd3, 8'h07);
    count_window(100, s, q);
    check(q == 0, "R5 count one no irq", q, 0);
    check(s >= 40, "R5 strobes still run", s, 40);

    // R2: count write before control word is ignored
    do_reset();
    wr(3'd0, 8'd4);
    wr(3'd0, 8'd0);
    prog(1'b1, 16'd3);
    wr(3'd3, 8'h07);
    count_window(40, s, q);
    check(s == 0, "R2 unarmed channel idle", s, 0);
    prog(1'b0, 16'd4);
    count_window(20, s, q);
    check(s >= 4, "R2 runs after control", s, 4);

    // R10: reset while interrupt pending
    check(irq == 1, "R10 irq before reset", irq, 1);
    do_reset();
    count_window(20, s, q);
    check(s == 0 && q == 0, "R10 reset clears", s + q, 0);

    // R4: block count 0 means 65536
    do_reset();
    prog(1'b0, 16'd2);
    prog(1'b1, 16'd0);
    wr(3'd3, 8'h07);
    run_block(2, 65536, 140000, "R4 zero count");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule